// File: doc/BRIEF.md
# Cascadable Down-Counting Interval Timer Bank

The block holds four reload timers, each one byte wide, reached through a small byte-addressed register port. Every timer has a control byte, a reload byte and a read-only view of its live counter. A running timer decrements once for every cycle in which the shared tick input is high. When it passes through one it reloads from its reload byte and emits a one-cycle underflow pulse. The interval between pulses is therefore exactly the reload value, counted in ticks.

A timer whose clock select is set to the chained code does not follow the tick. Instead it acts as the high byte of a 16-bit counter whose low byte is the timer just below it. The pair then runs with the period {upper reload, lower reload}, and only the lower timer pulses. Accesses of two or four bytes pack neighbouring timers' registers into one word, with the lower-numbered timer in the more significant byte. Illegal accesses and illegal control values are refused and flagged by a one-cycle error pulse.

Top module: `tmr_bank`

## Requirements
- R1: Register map. Byte offset 0x00+n is the control byte of timer n, 0x10+n its reload byte and 0x20+n its counter, for n = 0..3. Any other offset is refused. A refused access raises bus_err for exactly the cycle after the request and changes no state. Reset clears bus_rdata, bus_err and uflow.
- R2: Reads. bus_size 0, 1 and 2 mean 1, 2 and 4 bytes; size 3 is refused. A 2-byte access needs an even timer index and a 4-byte access needs index 0; other cases are refused. Read data appears zero-extended in bus_rdata the cycle after the request, with timer n in the most significant byte of the accessed group.
- R3: Reload writes follow the same size and alignment rules and the same packing. bus_wdata[15:8] goes to timer n and [7:0] to timer n+1 for 2 bytes; bus_wdata[31:24] goes to timer 0 for 4 bytes.
- R4: Control bit 7 is run, bit 6 is load, and bits 1:0 are the clock select (00 = tick, 11 = chained); bits 5:2 are reserved. A control write is refused if it is wider than one byte, sets a reserved bit, sets run and load together, uses select 01 or 10, or selects chained on timer 0. Writes to counter offsets are always refused.
- R5: While a timer is stopped, its counter reads back equal to its reload byte, including right after a reload write. While it is running, the counter reads the ticks left before the next underflow.
- R6: After a control write with run set and select 00, the first underflow pulse appears P tick-cycles later, where P is the reload value. Further pulses follow every P tick-cycles, and each pulse lasts one cycle.
- R7: Cycles with the tick input low do not advance any counter.
- R8: A reload write to a running timer leaves the current count alone. The new value is used from the next underflow on.
- R9: A reload value of zero produces no underflow pulses.
- R10: Clearing run stops the timer at once. Setting run again starts a fresh period from the reload value.
- R11: With timer n+1 set to chained and running, and timer n running on the tick, the pair counts the 16-bit period {reload n+1, reload n}. Only timer n pulses; the chained timer never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_tick | input | 1 | Count tick qualifier shared by all timers |
| bus_valid | input | 1 | Register access request for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, registered, held until the next legal read |
| bus_err | output | 1 | One-cycle pulse on a refused access |
| uflow | output | 4 | Per-timer underflow pulse |

## Verification
The bench builds the block with its default four timers, each eight bits wide. At that width a 4-byte access covers the whole bank, so every packing lane and every alignment refusal can be reached. A chained pair with a period of 260 crosses the low-byte borrow within a few hundred cycles. Small reload values such as 3 and 5 let the bench check exact pulse spacing, reloads that take effect late, and stop and restart, one tick at a time.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned MODE_W = 8;

  localparam logic [3:0] PAGE_MODE = 4'h0;
  localparam logic [3:0] PAGE_BASE = 4'h1;
  localparam logic [3:0] PAGE_CNT  = 4'h2;

  localparam logic [1:0] SZ_1 = 2'd0;
  localparam logic [1:0] SZ_2 = 2'd1;
  localparam logic [1:0] SZ_4 = 2'd2;

  localparam logic [1:0] CLK_TICK = 2'b00;
  localparam logic [1:0] CLK_CASC = 2'b11;

  localparam int unsigned MB_RUN  = 7;
  localparam int unsigned MB_LOAD = 6;

  typedef enum logic [1:0] {PG_MODE, PG_BASE, PG_CNT, PG_NONE} page_e;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
#(
  parameter int unsigned NT = 4,
  parameter int unsigned LW = 2
) (
  input  logic                      write,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [1:0]                size,
  input  logic [MODE_W-1:0]         mode_val,
  output page_e                     pg,
  output logic [NT-1:0]             sel,
  output logic [NT-1:0][LW-1:0]     lane,
  output logic                      err
);
  int unsigned idx;
  int unsigned nb;
  logic        range_ok;
  logic        align_ok;
  logic        val_bad;

  always_comb begin
    idx = int'(addr[3:0]);
    unique case (addr[7:4])
      PAGE_MODE: pg = PG_MODE;
      PAGE_BASE: pg = PG_BASE;
      PAGE_CNT:  pg = PG_CNT;
      default:   pg = PG_NONE;
    endcase
    unique case (size)
      SZ_1:    nb = 1;
      SZ_2:    nb = 2;
      SZ_4:    nb = 4;
      default: nb = 0;
    endcase
    range_ok = (nb != 0) && (idx + nb <= NT);
    align_ok = (nb == 1) || (nb == 2 && !addr[0]) || (nb == 4 && idx == 0);
    val_bad  = (mode_val[5:2] != '0)
            || (mode_val[MB_RUN] && mode_val[MB_LOAD])
            || (mode_val[1:0] == 2'b01) || (mode_val[1:0] == 2'b10)
            || (mode_val[1:0] == CLK_CASC && idx == 0);
    err = (pg == PG_NONE) || !range_ok || !align_ok
       || (write && pg == PG_CNT)
       || (write && pg == PG_MODE && (nb != 1 || val_bad));
    for (int i = 0; i < NT; i++) begin
      sel[i]  = (i >= idx) && (i < idx + nb);
      lane[i] = sel[i] ? LW'(nb - 1 - (i - idx)) : '0;
    end
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int unsigned TW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wd,
  input  logic              base_we,
  input  logic [TW-1:0]     base_wd,
  input  logic              below_step,
  input  logic              below_reload,
  input  logic              below_plain,
  input  logic              above_link,
  input  logic              above_zero,
  output logic [MODE_W-1:0] mode_q,
  output logic [TW-1:0]     base_q,
  output logic [TW-1:0]     cnt_q,
  output logic              uflow,
  output logic              step_o,
  output logic              reload_o,
  output logic              plain_o,
  output logic              link_o,
  output logic              zero_o
);
  logic [MODE_W-1:0] mode_n;
  logic [TW-1:0]     base_n, cnt_n;
  logic              uf_n, run, plain, casc;

  always_comb begin
    run      = mode_q[MB_RUN];
    plain    = (mode_q[1:0] == CLK_TICK);
    casc     = (mode_q[1:0] == CLK_CASC);
    plain_o  = plain;
    link_o   = casc && run && below_plain;
    zero_o   = (cnt_q == '0);
    mode_n   = mode_q;
    base_n   = base_q;
    cnt_n    = cnt_q;
    uf_n     = 1'b0;
    step_o   = 1'b0;
    reload_o = 1'b0;
    if (base_we) base_n = base_wd;
    if (mode_we) begin
      mode_n   = mode_wd;
      cnt_n    = base_q;
      reload_o = mode_wd[MB_RUN] && (mode_wd[1:0] == CLK_TICK);
    end else if (base_we && !run) begin
      cnt_n = base_wd;
    end else if (link_o) begin
      if (below_reload)    cnt_n = base_q;
      else if (below_step) cnt_n = cnt_q - 1'b1;
    end else if (plain && run && tick) begin
      if (cnt_q == TW'(1) && (!above_link || above_zero)) begin
        uf_n     = 1'b1;
        cnt_n    = base_q;
        reload_o = 1'b1;
      end else if (cnt_q == '0) begin
        if (above_link && !above_zero) begin
          cnt_n  = '1;
          step_o = 1'b1;
        end
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      uflow  <= 1'b0;
    end else begin
      mode_q <= mode_n;
      base_q <= base_n;
      cnt_q  <= cnt_n;
      uflow  <= uf_n;
    end
  end

  // R5
  stop_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base_we && !mode_we && !mode_q[MB_RUN]) |=> (cnt_q == $past(base_wd)));
  // R10
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[MB_RUN] && !mode_we && !base_we) |=> $stable(cnt_q));
  // R7
  uflow_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uflow |-> $past(tick));
  // R11
  uflow_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uflow |-> $past(mode_q[1:0] == CLK_TICK));
  // R9
  uflow_from_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uflow |-> ($past(cnt_q) == TW'(1)));
  // R4
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |-> (mode_wd[5:2] == '0 && !(mode_wd[MB_RUN] && mode_wd[MB_LOAD])));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_TMR = 4,
  parameter int unsigned TMR_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 io_tick,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [1:0]           bus_size,
  input  logic [4*TMR_W-1:0]   bus_wdata,
  output logic [4*TMR_W-1:0]   bus_rdata,
  output logic                 bus_err,
  output logic [NUM_TMR-1:0]   uflow
);
  localparam int unsigned DW = 4 * TMR_W;
  localparam int unsigned LW = 2;

  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  page_e                          pg;
  logic [NUM_TMR-1:0]             sel;
  logic [NUM_TMR-1:0][LW-1:0]     lane;
  logic                           dec_err, acc_ok;

  tmr_decode #(.NT(NUM_TMR), .LW(LW)) u_dec (
    .write(bus_write), .addr(bus_addr), .size(bus_size),
    .mode_val(bus_wdata[MODE_W-1:0]),
    .pg(pg), .sel(sel), .lane(lane), .err(dec_err)
  );
  assign acc_ok = bus_valid && !dec_err;

  logic [NUM_TMR-1:0]             mode_we, base_we;
  logic [NUM_TMR-1:0][TMR_W-1:0]  base_wd, base_q, cnt_q, rv;
  logic [NUM_TMR-1:0][MODE_W-1:0] mode_q;
  logic [NUM_TMR-1:0]             step, reload, plain, link, zero;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic b_step, b_reload, b_plain, a_link, a_zero;
    assign mode_we[i] = acc_ok && bus_write && pg == PG_MODE && sel[i];
    assign base_we[i] = acc_ok && bus_write && pg == PG_BASE && sel[i];
    assign base_wd[i] = TMR_W'(bus_wdata >> (int'(lane[i]) * TMR_W));
    if (i == 0) begin : g_bot
      assign b_step = 1'b0; assign b_reload = 1'b0; assign b_plain = 1'b0;
    end else begin : g_mid
      assign b_step = step[i-1]; assign b_reload = reload[i-1];
      assign b_plain = plain[i-1];
    end
    if (i == NUM_TMR - 1) begin : g_top
      assign a_link = 1'b0; assign a_zero = 1'b1;
    end else begin : g_low
      assign a_link = link[i+1]; assign a_zero = zero[i+1];
    end
    tmr_unit #(.TW(TMR_W)) u_unit (
      .clk(clk), .rst_n(rst_int_n), .tick(io_tick),
      .mode_we(mode_we[i]), .mode_wd(bus_wdata[MODE_W-1:0]),
      .base_we(base_we[i]), .base_wd(base_wd[i]),
      .below_step(b_step), .below_reload(b_reload), .below_plain(b_plain),
      .above_link(a_link), .above_zero(a_zero),
      .mode_q(mode_q[i]), .base_q(base_q[i]), .cnt_q(cnt_q[i]),
      .uflow(uflow[i]), .step_o(step[i]), .reload_o(reload[i]),
      .plain_o(plain[i]), .link_o(link[i]), .zero_o(zero[i])
    );
  end

  logic [DW-1:0] rdata_q, rdata_n;
  logic          err_n;

  always_comb begin
    for (int i = 0; i < NUM_TMR; i++) begin
      unique case (pg)
        PG_MODE: rv[i] = TMR_W'(mode_q[i]);
        PG_BASE: rv[i] = base_q[i];
        default: rv[i] = cnt_q[i];
      endcase
    end
    err_n   = bus_valid && dec_err;
    rdata_n = rdata_q;
    if (acc_ok && !bus_write) begin
      rdata_n = '0;
      for (int i = 0; i < NUM_TMR; i++)
        if (sel[i]) rdata_n = rdata_n | (DW'(rv[i]) << (int'(lane[i]) * TMR_W));
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rdata_q <= '0;
      bus_err <= 1'b0;
    end else begin
      rdata_q <= rdata_n;
      bus_err <= err_n;
    end
  end
  assign bus_rdata = rdata_q;

  // R1
  err_after_req_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_err |-> $past(bus_valid));
  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$past(bus_valid) |-> $stable(bus_rdata));
endmodule

// File: tb/tmr_bank_bench.sv
module tmr_bank_bench;
  localparam int NV = 26;
  // fields: wr, addr, size, wdata, exp_err, chk_rd, exp_rd, req tag
  localparam logic [80:0] VEC [NV] = '{
    {1'b1, 8'h10, 2'd2, 32'hA1B2C3D4, 1'b0, 1'b0, 32'h0,        4'd3}, // R3 4-byte reload write
    {1'b0, 8'h12, 2'd0, 32'h0,        1'b0, 1'b1, 32'h000000C3, 4'd3}, // R3
    {1'b0, 8'h10, 2'd1, 32'h0,        1'b0, 1'b1, 32'h0000A1B2, 4'd2}, // R2
    {1'b1, 8'h10, 2'd0, 32'h12,       1'b0, 1'b0, 32'h0,        4'd3}, // R3
    {1'b1, 8'h12, 2'd1, 32'h3456,     1'b0, 1'b0, 32'h0,        4'd3}, // R3 2-byte
    {1'b0, 8'h10, 2'd2, 32'h0,        1'b0, 1'b1, 32'h12B23456, 4'd2}, // R2
    {1'b1, 8'h11, 2'd0, 32'h78,       1'b0, 1'b0, 32'h0,        4'd3}, // R3
    {1'b0, 8'h10, 2'd1, 32'h0,        1'b0, 1'b1, 32'h00001278, 4'd2}, // R2
    {1'b0, 8'h21, 2'd0, 32'h0,        1'b0, 1'b1, 32'h00000078, 4'd5}, // R5
    {1'b0, 8'h20, 2'd2, 32'h0,        1'b0, 1'b1, 32'h12783456, 4'd5}, // R5
    {1'b1, 8'h00, 2'd1, 32'h0,        1'b1, 1'b0, 32'h0,        4'd4}, // R4 wide control
    {1'b1, 8'h00, 2'd0, 32'hC0,       1'b1, 1'b0, 32'h0,        4'd4}, // R4 run+load
    {1'b1, 8'h00, 2'd0, 32'h03,       1'b1, 1'b0, 32'h0,        4'd4}, // R4 chain on 0
    {1'b1, 8'h01, 2'd0, 32'h04,       1'b1, 1'b0, 32'h0,        4'd4}, // R4 reserved
    {1'b1, 8'h01, 2'd0, 32'h01,       1'b1, 1'b0, 32'h0,        4'd4}, // R4 select 01
    {1'b1, 8'h01, 2'd0, 32'h40,       1'b0, 1'b0, 32'h0,        4'd4}, // R4 load alone
    {1'b0, 8'h00, 2'd2, 32'h0,        1'b0, 1'b1, 32'h00400000, 4'd4}, // R4
    {1'b1, 8'h20, 2'd0, 32'h55,       1'b1, 1'b0, 32'h0,        4'd4}, // R4 counter write
    {1'b0, 8'h30, 2'd0, 32'h0,        1'b1, 1'b0, 32'h0,        4'd1}, // R1
    {1'b0, 8'h11, 2'd1, 32'h0,        1'b1, 1'b0, 32'h0,        4'd2}, // R2 odd 2-byte
    {1'b0, 8'h12, 2'd2, 32'h0,        1'b1, 1'b0, 32'h0,        4'd2}, // R2 4-byte not at 0
    {1'b0, 8'h04, 2'd0, 32'h0,        1'b1, 1'b0, 32'h0,        4'd1}, // R1 index past bank
    {1'b0, 8'h02, 2'd3, 32'h0,        1'b1, 1'b0, 32'h0,        4'd2}, // R2 size 3
    {1'b1, 8'h01, 2'd0, 32'h00,       1'b0, 1'b0, 32'h0,        4'd4}, // R4
    {1'b1, 8'h13, 2'd1, 32'hFFFF,     1'b1, 1'b0, 32'h0,        4'd3}, // R3 odd 2-byte write
    {1'b0, 8'h20, 2'd2, 32'h0,        1'b0, 1'b1, 32'h12783456, 4'd4}  // R4 no state change
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [3:0]  uflow;

  int checks = 0;
  int errors = 0;
  int u3_pulses = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_bank u_tmr_bank (
    .clk(clk), .rst_n(rst_n), .io_tick(tick),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .uflow(uflow)
  );

  always @(negedge clk) if (uflow[3] === 1'b1) u3_pulses++;

  task automatic check(input int tag, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic bus_op(input bit wr, input logic [7:0] a, input logic [1:0] sz,
                        input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 1'b0;
  endtask

  task automatic wait_pulse(input int idx, input int maxc, output int c);
    c = 0;
    do begin
      @(posedge clk); #1;
      c++;
    end while (uflow[idx] !== 1'b1 && c < maxc);
  endtask

  task automatic quiet(input int idx, input int n, output int seen);
    seen = 0;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      if (uflow[idx] === 1'b1) seen++;
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R6 watchdog expired: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    int seen;
    logic [80:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check(1, bus_rdata, 32'h0, "reset rdata");           // R1
    check(1, {31'h0, bus_err}, 32'h0, "reset err");      // R1
    check(1, {28'h0, uflow}, 32'h0, "reset uflow");      // R1

    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      bus_op(v[80], v[79:72], v[71:70], v[69:38]);
      check(int'(v[3:0]), {31'h0, bus_err}, {31'h0, v[37]}, $sformatf("vector %0d err", k));
      if (v[36]) check(int'(v[3:0]), bus_rdata, v[35:4], $sformatf("vector %0d rdata", k));
    end
    @(posedge clk); #1;
    check(1, {31'h0, bus_err}, 32'h0, "err lasts one cycle");  // R1

    // R6 period 3 on timer 0
    bus_op(1'b1, 8'h10, 2'd0, 32'h03);
    tick = 1'b1;
    bus_op(1'b1, 8'h00, 2'd0, 32'h80);
    wait_pulse(0, 50, c);
    check(6, c, 3, "first pulse delay");
    wait_pulse(0, 50, c);
    check(6, c, 3, "pulse interval");
    // R8 reload write while running
    bus_op(1'b1, 8'h10, 2'd0, 32'h05);
    wait_pulse(0, 50, c);
    check(8, c, 2, "current period unaffected");
    wait_pulse(0, 50, c);
    check(8, c, 5, "new period after reload");
    @(posedge clk); #1;
    bus_op(1'b0, 8'h20, 2'd0, 32'h0);
    check(5, bus_rdata, 32'h4, "running counter read");    // R5
    // R10 stop and restart
    bus_op(1'b1, 8'h00, 2'd0, 32'h00);
    quiet(0, 12, seen);
    check(10, seen, 0, "stopped timer pulses");
    bus_op(1'b0, 8'h20, 2'd0, 32'h0);
    check(5, bus_rdata, 32'h5, "stopped counter read");    // R5
    bus_op(1'b1, 8'h00, 2'd0, 32'h80);
    wait_pulse(0, 50, c);
    check(10, c, 5, "fresh period after restart");
    bus_op(1'b1, 8'h00, 2'd0, 32'h00);
    // R7 tick low
    tick = 1'b0;
    bus_op(1'b1, 8'h00, 2'd0, 32'h80);
    quiet(0, 20, seen);
    check(7, seen, 0, "pulses without tick");
    bus_op(1'b0, 8'h20, 2'd0, 32'h0);
    check(7, bus_rdata, 32'h5, "counter frozen without tick");
    bus_op(1'b1, 8'h00, 2'd0, 32'h00);
    tick = 1'b1;
    // R9 zero period
    bus_op(1'b1, 8'h11, 2'd0, 32'h00);
    bus_op(1'b1, 8'h01, 2'd0, 32'h80);
    quiet(1, 20, seen);
    check(9, seen, 0, "zero period pulses");
    bus_op(1'b1, 8'h01, 2'd0, 32'h00);
    // R11 chained pair 2/3, period 0x0104
    bus_op(1'b1, 8'h12, 2'd1, 32'h0401);
    bus_op(1'b1, 8'h03, 2'd0, 32'h83);
    u3_pulses = 0;
    bus_op(1'b1, 8'h02, 2'd0, 32'h80);
    wait_pulse(2, 400, c);
    check(11, c, 260, "chained first period");
    wait_pulse(2, 400, c);
    check(11, c, 260, "chained interval");
    check(11, u3_pulses, 0, "chained upper pulses");
    bus_op(1'b1, 8'h02, 2'd0, 32'h00);
    bus_op(1'b1, 8'h03, 2'd0, 32'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule